// File: doc/BRIEF.md
# UART FIFO Interrupt Controller

This block holds the receive and transmit byte queues of a serial port and decides whether the port raises an interrupt and which cause it reports. The receive datapath hands it bytes and error events through push strobes. The transmit datapath takes bytes from it through a pop strobe. Software reaches four register addresses through a plain address, write-data and read-data port. Reading the data address takes one received byte off the queue, and writing it queues one byte for sending.

A control write turns the queues on or off and sets the receive threshold. The same write can also flush either queue with one-shot bits. Three interrupt causes are ranked: line errors first, then received data at or above the threshold, then an emptied transmit queue. The highest enabled pending cause is shown as a 3-bit code in the identification byte and drives the `irq` output. The same status byte is read at address 3 and also driven on the `line_stat` port.

Top module: `uart_fifo_irq_ctrl`

## Requirements
- R1: With control bit 0 clear each queue holds one byte; with it set each holds 16. A receive push into a full queue is dropped and sets the overrun flag (status bit 1).
- R2: A control write with bit 1 set empties the receive queue, and bit 2 set empties the transmit queue, at that clock edge. Neither bit is retained, so later pushes are stored normally.
- R3: Control bits 7:6 choose the receive threshold: code 0 is 1 byte, 1 is 4, 2 is 8 and 3 is 14. With the queues off the threshold is 1.
- R4: Enable register (address 1) bit 0 gates the receive-data cause, bit 1 the transmit-empty cause and bit 2 the line-status cause. With all three clear, `irq` is low and identification bit 0 reads 1.
- R5: The identification byte (read at address 2) carries the cause code in bits 3:1: 3 for line status, 2 for receive data, 1 for transmit empty, 0 for none. Bit 0 is 0 while a cause is pending. Bits 7:6 both equal control bit 0.
- R6: When several enabled causes are pending, line status wins over receive data, and receive data wins over transmit empty.
- R7: The transmit-empty cause is set one cycle after the transmit queue empties through a `tx_pop`, or when enable bit 1 is written from 0 to 1 while the queue is empty. Writing a byte to address 0 clears it. So does reading the identification byte while it shows code 1.
- R8: The receive-data cause is pending while the receive count is at or above the threshold, and it drops when a read brings the count below the threshold.
- R9: Status bit 0 is set while the receive queue is not empty. Bit 5 is set while the transmit queue is not full, and bit 6 while it is empty. Bit 2 is a sticky flag set by `rx_err`. Reading address 3 clears bits 1 and 2.
- R10: After reset all enables are 0, the queues are off and empty, status reads 0x60, identification reads 0x01, and `irq` and `tx_ready` are low.
- R11: Address 0 reads the oldest received byte and pops it, and a write to it queues a transmit byte. `tx_byte` shows the oldest transmit byte while `tx_ready` is high. The enable register reads back bits 2:0, with bits 7:3 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| rx_push | input | 1 | Receive datapath delivers rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 1 | Receive datapath reports a line error |
| tx_pop | input | 1 | Transmit datapath takes tx_byte |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_ready | output | 1 | Transmit queue holds a byte |
| line_stat | output | 8 | Line status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench steps the receive threshold through all four codes. It pushes one byte short of each threshold and then one more. A design with an off-by-one compare, or with a linear code-to-level map, would raise `irq` one byte early or late. The bench overfills the queue in both depth modes: a design that stored the extra byte or skipped the overrun flag would hand back a wrong byte or show no overrun. It stacks all three causes at once and removes them one at a time, checking the code after each step. Wrong ranking, or a transmit-empty flag that does not clear when the identification byte is read, shows up as a wrong code.

// File: rtl/uart_fic_pkg.sv
package uart_fic_pkg;
  localparam logic [1:0] A_DATA  = 2'd0;
  localparam logic [1:0] A_IEN   = 2'd1;
  localparam logic [1:0] A_IDCTL = 2'd2;
  localparam logic [1:0] A_LSTAT = 2'd3;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TXE  = 3'd1,
    SRC_RXD  = 3'd2,
    SRC_LINE = 3'd3
  } src_e;

  // nonlinear receive threshold map
  function automatic int unsigned trig_chars(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_fic_rst_sync.sv
module uart_fic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/uart_fic_fifo.sv
module uart_fic_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       single,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = single ? (cnt_q != '0) : (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign drop    = push && full && !clr;
  assign dout    = mem[rd_q];
  assign count   = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = bump(wr_q);
      if (do_pop)  rd_d = bump(rd_q);
      if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R1
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == $past(count)));

  // R2
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/uart_fic_prio.sv
module uart_fic_prio
  import uart_fic_pkg::*;
(
  input  logic ls_pend,
  input  logic rxd_pend,
  input  logic txe_pend,
  output src_e src,
  output logic none
);
  always_comb begin
    if (ls_pend)       src = SRC_LINE;
    else if (rxd_pend) src = SRC_RXD;
    else if (txe_pend) src = SRC_TXE;
    else               src = SRC_NONE;
  end

  assign none = !(ls_pend || rxd_pend || txe_pend);
endmodule

// File: rtl/uart_fifo_irq_ctrl.sv
module uart_fifo_irq_ctrl
  import uart_fic_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_push,
  input  logic [7:0] rx_byte,
  input  logic       rx_err,
  input  logic       tx_pop,
  output logic [7:0] tx_byte,
  output logic       tx_ready,
  output logic [7:0] line_stat,
  output logic       irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic          rst_q_n;
  logic          fen_q, fen_d;
  logic [1:0]    trig_q, trig_d;
  logic [2:0]    ien_q, ien_d;
  logic          ovr_q, ovr_d, err_q, err_d, txe_q, txe_d, txmt_q;
  logic          wr_data, wr_ien, wr_ctl, rd_data, rd_id, rd_ls;
  logic [7:0]    rx_head;
  logic [CW-1:0] rx_cnt, tx_cnt, trig_lvl;
  logic          rx_full, rx_empty, rx_drop, tx_full, tx_empty, tx_drop;
  logic          ls_pend, rxd_pend, txe_pend, none;
  src_e          src;
  logic [7:0]    id_byte;

  uart_fic_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign wr_ctl  = reg_wr && (reg_addr == A_IDCTL);
  assign rd_data = reg_rd && (reg_addr == A_DATA);
  assign rd_id   = reg_rd && (reg_addr == A_IDCTL);
  assign rd_ls   = reg_rd && (reg_addr == A_LSTAT);

  uart_fic_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_q_n), .clr(wr_ctl && reg_wdata[1]), .single(!fen_q),
    .push(rx_push), .din(rx_byte), .pop(rd_data), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty), .drop(rx_drop)
  );

  uart_fic_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_q_n), .clr(wr_ctl && reg_wdata[2]), .single(!fen_q),
    .push(wr_data), .din(reg_wdata), .pop(tx_pop), .dout(tx_byte),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty), .drop(tx_drop)
  );

  // threshold, clamped to the queue depth
  always_comb begin
    int unsigned t;
    t = fen_q ? trig_chars(trig_q) : 1;
    if (t > DEPTH) t = DEPTH;
    trig_lvl = CW'(t);
  end

  assign ls_pend  = ien_q[2] && (ovr_q || err_q);
  assign rxd_pend = ien_q[0] && (rx_cnt >= trig_lvl);
  assign txe_pend = ien_q[1] && txe_q;

  uart_fic_prio u_prio (
    .ls_pend(ls_pend), .rxd_pend(rxd_pend), .txe_pend(txe_pend),
    .src(src), .none(none)
  );

  always_comb begin
    fen_d  = fen_q;
    trig_d = trig_q;
    ien_d  = ien_q;
    if (wr_ctl) begin
      fen_d  = reg_wdata[0];
      trig_d = reg_wdata[7:6];
    end
    if (wr_ien) ien_d = reg_wdata[2:0];

    ovr_d = rx_drop || (ovr_q && !rd_ls);
    err_d = rx_err  || (err_q && !rd_ls);

    if (wr_data)
      txe_d = 1'b0;
    else if ((tx_empty && !txmt_q) ||
             (wr_ien && reg_wdata[1] && !ien_q[1] && tx_empty))
      txe_d = 1'b1;
    else if (rd_id && (src == SRC_TXE))
      txe_d = 1'b0;
    else
      txe_d = txe_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      fen_q  <= 1'b0;
      trig_q <= 2'd0;
      ien_q  <= 3'd0;
      ovr_q  <= 1'b0;
      err_q  <= 1'b0;
      txe_q  <= 1'b0;
      txmt_q <= 1'b1;
    end else begin
      fen_q  <= fen_d;
      trig_q <= trig_d;
      ien_q  <= ien_d;
      ovr_q  <= ovr_d;
      err_q  <= err_d;
      txe_q  <= txe_d;
      txmt_q <= tx_empty;
    end
  end

  assign id_byte   = {fen_q, fen_q, 2'b00, src, none};
  assign line_stat = {1'b0, tx_empty, !tx_full, 2'b00, err_q, ovr_q, !rx_empty};
  assign tx_ready  = !tx_empty;
  assign irq       = !none;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rx_head;
      A_IEN:   reg_rdata = {5'b0, ien_q};
      A_IDCTL: reg_rdata = id_byte;
      default: reg_rdata = line_stat;
    endcase
  end

  // R4
  ien_off_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ien_q == 3'd0) |-> !irq);

  // R6
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ien_q[2] && (line_stat[1] || line_stat[2])) |-> (irq && id_byte[3:1] == 3'd3));

  // R7
  txe_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_data |=> !txe_q);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_err |=> line_stat[2]);

  // R1
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_drop |=> line_stat[1]);
endmodule

// File: tb/tb_uart_fifo_irq_ctrl.sv
module tb_uart_fifo_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       rx_push = 1'b0, rx_err = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_byte = '0, tx_byte, line_stat;
  logic       tx_ready, irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  always #4 clk = ~clk;

  uart_fifo_irq_ctrl dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares bytes leaving the design against the queues
  always @(negedge clk) begin
    #2;
    if (reg_rd && reg_addr == 2'd0) begin
      if (rxq.size() == 0) check("R11 rx underflow", 1, 0);
      else check("R11 rx byte", reg_rdata, rxq.pop_front());
    end
    if (tx_pop) begin
      if (txq.size() == 0) check("R11 tx underflow", 1, 0);
      else check("R11 tx byte", tx_byte, txq.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #3; d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rx_in(input logic [7:0] b, input bit kept);
    rx_byte = b; rx_push = 1'b1;
    if (kept) rxq.push_back(b);
    step();
    rx_push = 1'b0;
  endtask

  task automatic tx_put(input logic [7:0] b);
    txq.push_back(b);
    wr(2'd0, b);
  endtask

  task automatic tx_take();
    tx_pop = 1'b1;
    step();
    tx_pop = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    check("watchdog", 1, 0);
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check("R10 status", line_stat, 8'h60);
    check("R10 irq", irq, 0);
    check("R10 tx_ready", tx_ready, 0);
    rd(2'd2, d); check("R10 ident", d, 8'h01);
    rd(2'd1, d); check("R10 enables", d, 8'h00);

    // R1 queues off: second byte dropped, overrun flagged
    rx_in(8'hA5, 1);
    rx_in(8'h3C, 0);
    rd(2'd3, d); check("R1 overrun status", d, 8'h63);
    check("R9 read clears overrun", line_stat, 8'h61);
    rd(2'd0, d);
    check("R9 rx empty after read", line_stat[0], 0);

    // R1 queues on: sixteen kept, seventeenth dropped
    wr(2'd2, 8'h03);
    for (int i = 0; i < 16; i++) rx_in(8'(i * 7 + 1), 1);
    check("R1 no overrun at 16", line_stat[1], 0);
    rx_in(8'hEE, 0);
    check("R1 overrun at 17", line_stat[1], 1);
    for (int i = 0; i < 16; i++) rd(2'd0, d);
    check("R9 rx empty", line_stat[0], 0);
    rd(2'd3, d);

    // R3 / R8 thresholds 1,4,8,14
    wr(2'd1, 8'h01);
    for (int c = 0; c < 4; c++) begin
      int thr;
      thr = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
      wr(2'd2, 8'((c << 6) | 3));
      rxq.delete();
      for (int i = 0; i < thr - 1; i++) rx_in(8'(c * 16 + i), 1);
      check($sformatf("R3 below threshold code %0d", c), irq, 0);
      rx_in(8'h5A, 1);
      check($sformatf("R3 at threshold code %0d", c), irq, 1);
      rd(2'd2, d); check("R5 rx data code", d, 8'hC4);
      rd(2'd0, d);
      check($sformatf("R8 drop below code %0d", c), irq, 0);
    end
    wr(2'd2, 8'h03);
    rxq.delete();

    // R2 flush pulses, not retained
    rx_in(8'h11, 1); rx_in(8'h22, 1); rx_in(8'h33, 1);
    wr(2'd2, 8'h03); rxq.delete();
    check("R2 rx flushed", line_stat[0], 0);
    tx_put(8'h44); tx_put(8'h55);
    check("R9 tx not empty", line_stat[6], 0);
    wr(2'd2, 8'h05); txq.delete();
    check("R2 tx flushed", line_stat[6], 1);
    rx_in(8'h66, 1);
    check("R2 bit not retained", line_stat[0], 1);
    rd(2'd0, d);

    // R7 transmit empty
    wr(2'd1, 8'h02);
    check("R7 set on enable", irq, 1);
    rd(2'd2, d); check("R7 ident code 1", d, 8'hC2);
    rd(2'd2, d); check("R7 cleared by ident read", d, 8'hC1);
    tx_put(8'h81); tx_put(8'h82);
    check("R11 tx_ready", tx_ready, 1);
    tx_take();
    tx_take();
    check("R7 not yet set", irq, 0);
    step();
    check("R7 set after drain", irq, 1);
    tx_put(8'h83);
    check("R7 cleared by write", irq, 0);
    tx_take();
    step();

    // R6 ranking
    wr(2'd1, 8'h07);
    rx_in(8'h99, 1);
    rx_err = 1'b1; step(); rx_err = 1'b0;
    rd(2'd2, d); check("R6 line first", d, 8'hC6);
    rd(2'd3, d); check("R9 error bit", d[2], 1);
    rd(2'd2, d); check("R6 rx data next", d, 8'hC4);
    rd(2'd0, d);
    rd(2'd2, d); check("R6 tx empty last", d, 8'hC2);
    rd(2'd2, d); check("R5 none pending", d, 8'hC1);

    // R4 / R5 / R11 with queues off
    wr(2'd2, 8'h00);
    rx_in(8'h77, 1);
    wr(2'd1, 8'h00);
    check("R4 irq masked", irq, 0);
    rd(2'd2, d); check("R4 ident masked", d, 8'h01);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R11 enable readback", d, 8'h07);
    rd(2'd2, d); check("R5 bits 7:6 off", d, 8'h04);
    rd(2'd0, d);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule